// File: doc/BRIEF.md
# SDRAM access controller

This block lets a simple host port use one rank of four-bank single-data-rate SDRAM. After reset it brings the memory up. It holds CKE high and sends no-operations for a set number of cycles. It then closes every bank, issues two auto refreshes and programs the mode register. From then on it accepts single-word host requests. Each request becomes an activate followed by a read or a write with auto precharge. Between requests the controller inserts auto refreshes often enough to meet the refresh interval.

Every command spacing is a whole number of clocks, set by parameters whose defaults suit a 100 MHz clock. Command, bank, address, mask and write data pins are driven from registers, so each command occupies exactly one clock cycle on the bus. Read data is sampled from the data input after the programmed CAS latency and is returned with a one-cycle valid strobe.

Top module: `sdram_ctrl`

## Requirements
- R1: After reset, CKE goes high and only no-operations are issued for at least INIT_CYCLES-1 cycles. The first four commands are then, in order: precharge with A10 high, auto refresh, auto refresh, mode register set.
- R2: The mode register set carries BA=0 and an address word with CAS_LAT in A6..A4, 0 in A3 (sequential order), 000 in A2..A0 (burst of one) and 0 elsewhere. The cycle that follows it is a no-operation.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as mode set 0000, refresh 0001, activate 0011, read 0101, write 0100, precharge 0010, no-operation 0111. After initialisation only activate, read, write, refresh and no-operation appear. A read or write matches the direction of the accepted request (req_write 1 = write).
- R4: The word address maps as row = req_addr[21:10] on A11..A0 at activate, bank = req_addr[9:8] on BA, and column = req_addr[7:0] on A7..A0 at the read or write.
- R5: A read or write follows its activate by exactly T_RCD cycles, on the same bank, with A10 high to request auto precharge.
- R6: Two activates are at least T_RC cycles apart, and an activate follows a refresh by at least T_RC cycles.
- R7: The data output enable is high only in a write command cycle. In that cycle sd_dq_out carries the write data and sd_dqm carries req_mask, where a mask bit of 1 leaves that byte of memory unchanged.
- R8: A read drives sd_dqm to zero. Its data is taken from sd_dq_in CAS_LAT cycles after the memory samples the read. The result appears on rsp_data with rsp_valid high for one cycle, CAS_LAT+1 cycles after the read command cycle.
- R9: After initialisation, two consecutive refresh commands are never more than REF_PERIOD cycles apart, whether or not the host is busy.
- R10: req_ready is high only when an activate issued in the next cycle would be at least T_RC cycles after the last activate and after the last refresh. A request is taken only in a cycle where req_valid and req_ready are both high.
- R11: req_ready stays low from reset until the mode register set has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {row, bank, column} |
| req_wdata | input | 64 | Write data |
| req_mask | input | 8 | Per-byte write mask, 1 = keep old byte |
| rsp_data | output | 64 | Read data |
| rsp_valid | output | 1 | One-cycle strobe for rsp_data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed row/column/mode address |
| sd_dqm | output | 8 | Byte mask to the memory |
| sd_dq_out | output | 64 | Write data to the memory |
| sd_dq_oe | output | 1 | Enable for the data bus drivers |
| sd_dq_in | input | 64 | Read data from the memory |

## Verification
The bench builds the controller with INIT_CYCLES at 20, REF_PERIOD at 200 and CAS_LAT at 2. The other spacings keep their 100 MHz defaults. The short power-up wait lets the whole start-up order be observed in a few dozen cycles. The short refresh period makes refreshes fall in the middle of host traffic and several times during an idle stretch, so both the refresh ceiling and the ready blocking around refresh are exercised. The memory model takes its read latency from the mode word that the controller writes, so a wrong latency field shows up as a data mismatch.

// File: rtl/sdr_pkg.sv
// Shared definitions for the SDRAM access controller.
// Command codes are the {cs_n,ras_n,cas_n,we_n} pin pattern.
package sdr_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    // Sequencer state: names the next command to issue once the spacing wait is over.
    typedef enum logic [2:0] {
        ST_PWR,
        ST_IREF,
        ST_MRS,
        ST_IDLE,
        ST_COL
    } seq_state_e;

endpackage

// File: rtl/sdr_refresh_timer.sv
// Refresh interval timer.
// Counts cycles since the last refresh and raises `due` DUE_AT cycles later.
// Assumes the sequencer turns `due` into a refresh within GUARD cycles.
module sdr_refresh_timer #(
    parameter int REF_PERIOD = 1562,
    parameter int GUARD      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic due
);
    localparam int DUE_AT = REF_PERIOD - GUARD;
    localparam int CNT_W  = $clog2(REF_PERIOD + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count up from the last refresh and hold at the due point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_W'(DUE_AT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign due = (cnt_q == CNT_W'(DUE_AT));

endmodule

// File: rtl/sdr_read_capture.sv
// Read return path.
// Delays the read-issue flag through CAS_LAT+1 stages, then samples the data bus once.
// Assumes rd_issue is high in the cycle before the read command appears on the pins.
module sdr_read_capture #(
    parameter int CAS_LAT = 3,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [CAS_LAT:0] stage_q;

    // First stage: marks the cycle the read command is on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= rd_issue;
    end

    // Remaining stages: one per cycle of CAS latency.
    for (genvar g = 1; g <= CAS_LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= 1'b0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    // Sample the bus at the edge where the memory's data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= stage_q[CAS_LAT];
            if (stage_q[CAS_LAT]) rsp_data <= dq_in;
        end
    end

endmodule

// File: rtl/sdram_ctrl.sv
// SDRAM access controller, top level.
// Runs power-up, mode programming, periodic refresh and single-word accesses
// (activate, then read or write with auto precharge). Assumes one rank of four banks,
// burst length one, and that every spacing parameter is given in clock cycles.
module sdram_ctrl
    import sdr_pkg::*;
#(
    parameter int INIT_CYCLES = 20000,
    parameter int CAS_LAT     = 3,
    parameter int T_RCD       = 2,
    parameter int T_RP        = 2,
    parameter int T_RAS       = 5,
    parameter int T_RC        = 7,
    parameter int T_MRD       = 2,
    parameter int REF_PERIOD  = 1562,
    parameter int ROW_W       = 12,
    parameter int COL_W       = 8,
    parameter int BA_W        = 2,
    parameter int DATA_W      = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [ROW_W+BA_W+COL_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic [DATA_W/8-1:0]          req_mask,
    output logic [DATA_W-1:0]            rsp_data,
    output logic                         rsp_valid,
    output logic                         sd_cke,
    output logic                         sd_cs_n,
    output logic                         sd_ras_n,
    output logic                         sd_cas_n,
    output logic                         sd_we_n,
    output logic [BA_W-1:0]              sd_ba,
    output logic [ROW_W-1:0]             sd_a,
    output logic [DATA_W/8-1:0]          sd_dqm,
    output logic [DATA_W-1:0]            sd_dq_out,
    output logic                         sd_dq_oe,
    input  logic [DATA_W-1:0]            sd_dq_in
);
    localparam int MASK_W    = DATA_W / 8;
    localparam int ADDR_W    = ROW_W + BA_W + COL_W;
    localparam int AP_BIT    = 10;
    localparam int T_CYCLE   = (T_RC > T_RAS + T_RP) ? T_RC : (T_RAS + T_RP);
    localparam int COL_WAIT  = T_CYCLE - T_RCD - 1;
    localparam int WAIT_MAX  = (INIT_CYCLES > T_CYCLE) ? INIT_CYCLES : T_CYCLE;
    localparam int WAIT_W    = $clog2(WAIT_MAX + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    seq_state_e         state_q;
    logic [WAIT_W-1:0]  wait_q;
    logic               second_ref_q;
    sdr_cmd_e           cmd_q;
    logic               wr_q;
    logic [COL_W-1:0]   col_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [MASK_W-1:0]  mask_q;
    logic [ROW_W-1:0]   col_word;
    logic               ref_due;
    logic               ref_issue;
    logic               rd_issue;
    logic               spacing_done;

    assign spacing_done = (wait_q == '0);
    assign req_ready    = spacing_done && (state_q == ST_IDLE) && !ref_due;
    assign ref_issue    = spacing_done && ((state_q == ST_IREF) ||
                                           ((state_q == ST_IDLE) && ref_due));
    assign rd_issue     = spacing_done && (state_q == ST_COL) && !wr_q;

    // Column address word: column bits plus the auto-precharge flag.
    always_comb begin
        col_word             = '0;
        col_word[COL_W-1:0]  = col_q;
        col_word[AP_BIT]     = 1'b1;
    end

    // Command sequencer: waits out each spacing, then issues the next command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_PWR;
            wait_q       <= WAIT_W'(INIT_CYCLES - 1);
            second_ref_q <= 1'b0;
            cmd_q        <= CMD_NOP;
            sd_cke       <= 1'b0;
            sd_ba        <= '0;
            sd_a         <= '0;
            sd_dqm       <= '0;
            sd_dq_out    <= '0;
            sd_dq_oe     <= 1'b0;
            wr_q         <= 1'b0;
            col_q        <= '0;
            wdata_q      <= '0;
            mask_q       <= '0;
        end else begin
            sd_cke   <= 1'b1;
            cmd_q    <= CMD_NOP;
            sd_dq_oe <= 1'b0;
            sd_dqm   <= '0;
            if (!spacing_done) begin
                wait_q <= wait_q - 1'b1;
            end else begin
                case (state_q)
                    ST_PWR: begin
                        cmd_q        <= CMD_PRE;
                        sd_a         <= '0;
                        sd_a[AP_BIT] <= 1'b1;
                        wait_q       <= WAIT_W'(T_RP - 1);
                        state_q      <= ST_IREF;
                    end
                    ST_IREF: begin
                        cmd_q        <= CMD_REF;
                        wait_q       <= WAIT_W'(T_CYCLE - 1);
                        second_ref_q <= 1'b1;
                        if (second_ref_q) state_q <= ST_MRS;
                    end
                    ST_MRS: begin
                        cmd_q   <= CMD_MRS;
                        sd_ba   <= '0;
                        sd_a    <= MODE_WORD;
                        wait_q  <= WAIT_W'(T_MRD - 1);
                        state_q <= ST_IDLE;
                    end
                    ST_IDLE: begin
                        if (ref_due) begin
                            cmd_q  <= CMD_REF;
                            wait_q <= WAIT_W'(T_CYCLE - 1);
                        end else if (req_valid) begin
                            cmd_q   <= CMD_ACT;
                            sd_ba   <= req_addr[COL_W +: BA_W];
                            sd_a    <= req_addr[ADDR_W-1 -: ROW_W];
                            wr_q    <= req_write;
                            col_q   <= req_addr[COL_W-1:0];
                            wdata_q <= req_wdata;
                            mask_q  <= req_mask;
                            wait_q  <= WAIT_W'(T_RCD - 1);
                            state_q <= ST_COL;
                        end
                    end
                    ST_COL: begin
                        cmd_q     <= wr_q ? CMD_WR : CMD_RD;
                        sd_a      <= col_word;
                        sd_dq_oe  <= wr_q;
                        sd_dq_out <= wdata_q;
                        sd_dqm    <= wr_q ? mask_q : '0;
                        wait_q    <= WAIT_W'(COL_WAIT);
                        state_q   <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

    sdr_refresh_timer #(
        .REF_PERIOD (REF_PERIOD),
        .GUARD      (T_CYCLE + 1)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ref_issue),
        .due     (ref_due)
    );

    sdr_read_capture #(
        .CAS_LAT (CAS_LAT),
        .DATA_W  (DATA_W)
    ) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issue  (rd_issue),
        .dq_in     (sd_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/sdram_ctrl_chk.sv
// Protocol checker for sdram_ctrl, attached by bind.
// Watches only the pins and the host handshake; keeps its own cycle counters.
module sdram_ctrl_chk
    import sdr_pkg::*;
#(
    parameter int T_RCD      = 2,
    parameter int T_CYCLE    = 7,
    parameter int REF_PERIOD = 1562,
    parameter int ROW_W      = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_a,
    input logic             sd_dq_oe,
    input logic             req_ready,
    input logic             rsp_valid
);
    localparam int CW = $clog2(REF_PERIOD + T_CYCLE + 4) + 1;
    localparam logic [CW-1:0] SAT = '1;

    logic [3:0]    pins;
    logic          is_col;
    logic [CW-1:0] since_act;
    logic [CW-1:0] since_ref;
    logic          ref_seen;
    logic          mrs_seen;

    assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_col = (pins == CMD_RD) || (pins == CMD_WR);

    // Cycles since the last activate and the last refresh, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= SAT;
            since_ref <= SAT;
            ref_seen  <= 1'b0;
            mrs_seen  <= 1'b0;
        end else begin
            if (pins == CMD_ACT)     since_act <= '0;
            else if (since_act != SAT) since_act <= since_act + 1'b1;
            if (pins == CMD_REF)     since_ref <= '0;
            else if (since_ref != SAT) since_ref <= since_ref + 1'b1;
            if (pins == CMD_REF) ref_seen <= 1'b1;
            if (pins == CMD_MRS) mrs_seen <= 1'b1;
        end
    end

    // R2
    mrs_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_MRS) |=> (pins == CMD_NOP));

    // R5
    col_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act == CW'(T_RCD - 1)));

    // R5
    auto_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> sd_a[10]);

    // R6
    act_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_ACT) |-> ((since_act >= CW'(T_CYCLE - 1)) && (since_ref >= CW'(T_CYCLE - 1))));

    // R7
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (pins == CMD_WR));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    ref_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_seen |-> (since_ref < CW'(REF_PERIOD)));

    // R10
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((since_act >= CW'(T_CYCLE - 2)) && (since_ref >= CW'(T_CYCLE - 2))));

    // R11
    ready_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mrs_seen);

endmodule

bind sdram_ctrl sdram_ctrl_chk #(
    .T_RCD      (T_RCD),
    .T_CYCLE    (T_CYCLE),
    .REF_PERIOD (REF_PERIOD),
    .ROW_W      (ROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_a      (sd_a),
    .sd_dq_oe  (sd_dq_oe),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/test_sdram_ctrl.sv
// Scoreboard bench: the driver pushes expected read data, a monitor pops and compares.
// A small memory model answers the command pins and takes its latency from the mode word.
module test_sdram_ctrl;
    localparam int P_INIT = 20;
    localparam int P_CL   = 2;
    localparam int P_REF  = 200;
    localparam int P_RCD  = 2;
    localparam int P_RC   = 7;

    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                           C_NOP = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_mask = '0;
    logic [63:0] rsp_data;
    logic        rsp_valid;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_a;
    logic [7:0]  sd_dqm;
    logic [63:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [63:0] sd_dq_in = '0;

    sdram_ctrl #(
        .INIT_CYCLES (P_INIT),
        .CAS_LAT     (P_CL),
        .REF_PERIOD  (P_REF)
    ) i_sdram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [63:0] shadow [int];
    logic [63:0] dram [int];
    logic [63:0] exp_q [$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor and memory model state
    int ev_idx = 0, nop_cnt = 0, mrs_cyc = -1000, last_act = -1000, last_ref = -1000;
    int rd_cyc = -1000, rd_due = -1, model_cl = 0, ref_total = 0;
    int viol_oe = 0, viol_ready = 0;
    bit rd_pend = 0;
    int rd_key = 0;
    logic [11:0] act_row [4];
    logic [21:0] acc_addr;
    logic [63:0] acc_data;
    logic [7:0]  acc_mask;
    logic        acc_wr;

    always @(negedge clk) begin : monitor
        logic [3:0] c;
        int k;
        logic [63:0] old;
        if (rst_n) begin
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (c[3]) c = C_NOP;
            if (sd_dq_oe && c != C_WR) viol_oe++;
            if (req_ready && ((cyc + 1 - last_act) < P_RC || (cyc + 1 - last_ref) < P_RC)) viol_ready++;
            // R11: ready must stay low until the mode set is out
            if (req_ready && ev_idx < 4) chk(0, "R11 ready during init", 64'(req_ready), 64'd0);
            // Scoreboard: compare returned read data in order
            if (rsp_valid) begin
                chk(cyc == rd_cyc + P_CL + 1, "R8 read return cycle", 64'(cyc), 64'(rd_cyc + P_CL + 1));
                if (exp_q.size() == 0) chk(0, "R8 unexpected response", rsp_data, 64'd0);
                else begin
                    old = exp_q.pop_front();
                    chk(rsp_data == old, "R8 read data", rsp_data, old);
                end
            end
            // Memory model data return
            if (rd_pend && cyc == rd_due) begin
                sd_dq_in = dram.exists(rd_key) ? dram[rd_key] : 64'd0;
                rd_pend = 0;
            end else sd_dq_in = 64'hDEAD_BEEF_0BAD_F00D;
            if (c == C_NOP) begin
                if (ev_idx == 0) nop_cnt++;
            end else begin
                if (ev_idx == 0) begin
                    chk(nop_cnt >= P_INIT - 1, "R1 power-up wait", 64'(nop_cnt), 64'(P_INIT - 1));
                    chk(c == C_PRE && sd_a[10], "R1 precharge-all first", {c, sd_a}, {C_PRE, 12'h400});
                end else if (ev_idx < 3) begin
                    chk(c == C_REF, "R1 init refresh", 64'(c), 64'(C_REF));
                end else if (ev_idx == 3) begin
                    chk(c == C_MRS && sd_ba == 2'd0, "R1 mode set fourth", 64'(c), 64'(C_MRS));
                    chk(sd_a == 12'(P_CL << 4), "R2 mode word", 64'(sd_a), 64'(P_CL << 4));
                    model_cl = int'(sd_a[6:4]);
                    mrs_cyc = cyc;
                end else begin
                    if (ev_idx == 4) chk(cyc - mrs_cyc >= 2, "R2 mode set lockout", 64'(cyc - mrs_cyc), 64'd2);
                    case (c)
                        C_ACT: begin
                            chk(sd_ba == acc_addr[9:8] && sd_a == acc_addr[21:10], "R4 activate bank/row",
                                {sd_ba, sd_a}, {acc_addr[9:8], acc_addr[21:10]});
                            chk(cyc - last_act >= P_RC && cyc - last_ref >= P_RC, "R6 activate spacing",
                                64'(cyc - last_act), 64'(P_RC));
                            act_row[sd_ba] = sd_a;
                            last_act = cyc;
                        end
                        C_RD, C_WR: begin
                            chk(cyc - last_act == P_RCD, "R5 column delay", 64'(cyc - last_act), 64'(P_RCD));
                            chk(sd_a[10] == 1'b1, "R5 auto precharge", 64'(sd_a), 64'h400);
                            chk(sd_a[7:0] == acc_addr[7:0] && sd_ba == acc_addr[9:8], "R4 column/bank",
                                {sd_ba, sd_a[7:0]}, {acc_addr[9:8], acc_addr[7:0]});
                            chk((c == C_WR) == acc_wr, "R3 direction", 64'(c), acc_wr ? 64'(C_WR) : 64'(C_RD));
                            k = int'({sd_ba, act_row[sd_ba], sd_a[7:0]});
                            if (c == C_WR) begin
                                chk(sd_dq_oe && sd_dq_out == acc_data && sd_dqm == acc_mask, "R7 write data/mask",
                                    sd_dq_out, acc_data);
                                old = dram.exists(k) ? dram[k] : 64'd0;
                                for (int b = 0; b < 8; b++)
                                    if (!sd_dqm[b]) old[b*8 +: 8] = sd_dq_out[b*8 +: 8];
                                dram[k] = old;
                            end else begin
                                chk(sd_dqm == 8'd0 && !sd_dq_oe, "R8 read mask/oe", {sd_dqm, 7'd0, sd_dq_oe}, 64'd0);
                                rd_pend = 1; rd_key = k; rd_cyc = cyc; rd_due = cyc + model_cl;
                            end
                        end
                        C_REF: begin
                            chk(cyc - last_ref <= P_REF, "R9 refresh ceiling", 64'(cyc - last_ref), 64'(P_REF));
                            chk(cyc - last_act >= P_RC, "R6 activate to refresh", 64'(cyc - last_act), 64'(P_RC));
                            ref_total++;
                        end
                        default: chk(0, "R3 illegal command", 64'(c), 64'(C_NOP));
                    endcase
                end
                if (c == C_REF) last_ref = cyc;
                ev_idx++;
            end
            if (req_valid && req_ready) begin
                acc_addr = req_addr; acc_data = req_wdata; acc_mask = req_mask; acc_wr = req_write;
            end
        end
    end

    // Driver: called just after a rising edge; holds the request until it is taken.
    task automatic issue(input bit wr, input logic [21:0] addr, input logic [63:0] d, input logic [7:0] m);
        logic [63:0] v;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = d; req_mask = m;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        v = shadow.exists(int'(addr)) ? shadow[int'(addr)] : 64'd0;
        if (wr) begin
            for (int b = 0; b < 8; b++) if (!m[b]) v[b*8 +: 8] = d[b*8 +: 8];
            shadow[int'(addr)] = v;
        end else exp_q.push_back(v);
        @(posedge clk);
        #2 req_valid = 1'b0;
    endtask

    function automatic logic [21:0] mk(input int row, input int bank, input int col);
        return {12'(row), 2'(bank), 8'(col)};
    endfunction

    initial begin : main
        int ref_before;
        repeat (3) @(posedge clk);
        #2;
        // R1 / R11: state held in reset
        chk(sd_cke == 1'b0 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && !sd_dq_oe,
            "R1 reset outputs", {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {1'b0, C_NOP});
        chk(!req_ready && !rsp_valid, "R11 reset ready", 64'(req_ready), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk(sd_cke == 1'b1, "R1 cke high", 64'(sd_cke), 64'd1);
        // One write and one read per bank, distinct rows
        for (int b = 0; b < 4; b++) issue(1, mk(100 + b, b, 3 * b), {16'(b), 48'h1234_5678_9ABC}, 8'h00);
        for (int b = 0; b < 4; b++) issue(0, mk(100 + b, b, 3 * b), '0, 8'h00);
        // R7: fully masked write leaves memory unchanged; partial mask merges bytes
        issue(1, mk(101, 1, 3), 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        issue(0, mk(101, 1, 3), '0, 8'h00);
        issue(1, mk(102, 2, 6), 64'h1111_2222_3333_4444, 8'h5A);
        issue(0, mk(102, 2, 6), '0, 8'h00);
        // Same bank, different rows back to back; top row and column corners
        issue(1, mk(12'hFFF, 3, 8'hFF), 64'hCAFE_0000_0000_0001, 8'h00);
        issue(1, mk(0, 3, 0), 64'h0000_0000_0000_BEEF, 8'h00);
        issue(0, mk(12'hFFF, 3, 8'hFF), '0, 8'h00);
        issue(0, mk(0, 3, 0), '0, 8'h00);
        // Mixed traffic long enough to meet several refreshes
        for (int i = 0; i < 60; i++) begin
            issue(1, 22'((i * 40503 + 17) & 22'h3FFFFF), {32'(i * 7919), 32'(~i)}, 8'((i * 37) & 8'h3C));
            issue(0, 22'((i * 40503 + 17) & 22'h3FFFFF), '0, 8'h00);
        end
        // Idle stretch: refreshes keep coming
        ref_before = ref_total;
        repeat (700) @(posedge clk);
        #2;
        chk(ref_total - ref_before >= 3, "R9 idle refreshes", 64'(ref_total - ref_before), 64'd3);
        issue(0, mk(100, 0, 0), '0, 8'h00);
        repeat (20) @(posedge clk);
        #2;
        chk(exp_q.size() == 0, "R8 all reads returned", 64'(exp_q.size()), 64'd0);
        chk(viol_oe == 0, "R7 oe only on writes", 64'(viol_oe), 64'd0);
        chk(viol_ready == 0, "R10 ready gap", 64'(viol_ready), 64'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule